// File: doc/BRIEF.md
# Power-Fail Supervisor with Memory Write-Protect

This block supervises a processor's power. A digital power-good flag from an external comparator tells it whether the supply is within tolerance. From that flag it produces three things:

- a processor reset, active low;
- an interrupt, active low;
- a gated chip-enable that write-protects an external SRAM while power is bad.

When power fails, the interrupt is raised one clock before the reset, so software gets warning. Once power comes back, the reset is held for a stretch period before it is released.

The reset line is shared. The block pulls it low, and it also reads the line's level back. If something outside holds the line low for longer than a minimum time and then lets go, the block starts a full reset cycle of its own. A low shorter than that minimum is ignored.

Memory protection does not cut off an access that is already running. If the chip-enable was already asserted when power failed, that access keeps its enable for a bounded grace time, or until it ends, whichever comes first. An access that starts during the failure never gets through.

Reset and interrupt are open-drain. Each appears as a pull enable: 1 means the line is pulled low, and the block never drives either line high. All three time limits are parameters counted in microsecond ticks.

Top module: `pwr_supervisor`

## Requirements
- R1: While `rst_n` is low, `rst_pull` = 1, `int_pull` = 1 and `ce_out_n` = 1. After reset the block assumes power is bad until `pwr_good` has been sampled high.
- R2: When `pwr_good` is sampled low, `rst_pull` is 1 from the second clock edge onward. It stays 1 for as long as `pwr_good` stays low.
- R3: On a failure that starts with the reset released, `int_pull` rises at the first edge after `pwr_good` falls. `rst_pull` rises one edge later.
- R4: After `pwr_good` returns, `rst_pull` stays 1 until exactly `STRETCH_US` ticks have been counted, and then falls to 0. A failure during the stretch restarts the count from zero once power returns.
- R5: With the reset released, suppose the sensed pin `rst_pin_in` stays low for at least `PB_MIN_US`+1 ticks and then goes high. The block then sets `rst_pull` = 1 and runs a full stretch of `STRETCH_US` ticks.
- R6: An external low on `rst_pin_in` that lasts `PB_MIN_US` ticks or fewer has no effect: `rst_pull` stays 0.
- R7: While power is good, `ce_out_n` equals `ce_in_n`.
- R8: If `ce_in_n` is 0 when power fails, `ce_out_n` stays 0 until whichever comes first: `ce_in_n` goes to 1, or `GRACE_US` ticks have passed. After that, `ce_out_n` is 1.
- R9: A falling edge of `ce_in_n` during a failure leaves `ce_out_n` at 1.
- R10: `int_pull` is 1 whenever power is failed, `per_req` = 1 or `alm_req` = 1. It is 0 only when none of these holds. The block never clears the requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the logic |
| us_tick | input | 1 | One-cycle pulse each microsecond |
| pwr_good | input | 1 | 1 = supply within tolerance |
| ce_in_n | input | 1 | Incoming SRAM chip-enable, active low |
| rst_pin_in | input | 1 | Sensed level of the shared reset line |
| per_req | input | 1 | Periodic interrupt request, level |
| alm_req | input | 1 | Alarm interrupt request, level |
| rst_pull | output | 1 | 1 = pull the reset line low |
| int_pull | output | 1 | 1 = pull the interrupt line low |
| ce_out_n | output | 1 | Gated SRAM chip-enable, active low |

## Verification
A table first sweeps chip-enable, periodic and alarm requests with power held steady. This separates the interrupt OR from the chip-enable pass-through, and it separates a failure with no access from an access that begins during the failure.

Directed sequences then probe the timing edges:
- the stretch release, one tick before and at the limit, with a restart after a failure in mid-stretch;
- button lows of exactly `PB_MIN_US` ticks and of one tick more;
- the grace window, ended once by the enable returning high and once by the tick limit.

Each of these sequences tells an off-by-one count from a correct one.

// File: rtl/psv_pkg.sv
package psv_pkg;

  typedef enum logic [1:0] {
    SEQ_HOLD    = 2'd0,
    SEQ_STRETCH = 2'd1,
    SEQ_RUN     = 2'd2
  } seq_state_t;

  // True when one more tick completes a window of lim ticks.
  function automatic logic at_limit(input logic [31:0] cnt, input logic [31:0] lim);
    return (cnt + 32'd1) >= lim;
  endfunction

  // True when a low phase of cnt ticks exceeds the minimum.
  function automatic logic long_enough(input logic [31:0] cnt, input logic [31:0] min_us);
    return cnt > min_us;
  endfunction

endpackage

// File: rtl/psv_pin_qual.sv
module psv_pin_qual #(
  parameter int PB_MIN_US = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic pin_raw,
  input  logic pulling,
  output logic pb_event
);
  import psv_pkg::*;

  localparam int CW = $clog2(PB_MIN_US + 2) + 1;
  localparam logic [CW-1:0] SAT = CW'(PB_MIN_US + 1);

  logic          pin_m, pin_s;
  logic          armed;
  logic [CW-1:0] low_cnt;
  logic          low_ext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_m <= 1'b0;
      pin_s <= 1'b0;
    end else begin
      pin_m <= pin_raw;
      pin_s <= pin_m;
    end
  end

  // Armed only once the line reads high with our own pull released.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       armed <= 1'b0;
    else if (pulling) armed <= 1'b0;
    else if (pin_s)   armed <= 1'b1;
  end

  assign low_ext = armed & ~pin_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           low_cnt <= '0;
    else if (!low_ext)                    low_cnt <= '0;
    else if (tick && low_cnt != SAT)      low_cnt <= low_cnt + CW'(1);
  end

  assign pb_event = armed & pin_s & long_enough(32'(low_cnt), 32'(PB_MIN_US));

  // R5: a qualified release directly follows a sensed low
  p_pb_after_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pb_event |-> $past(!pin_s));

endmodule

// File: rtl/psv_rst_seq.sv
module psv_rst_seq #(
  parameter int STRETCH_US = 200000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic fail,
  input  logic pb_event,
  output logic hold_o
);
  import psv_pkg::*;

  localparam int CW = $clog2(STRETCH_US + 1);

  seq_state_t    state;
  logic [CW-1:0] cnt;
  logic          stretch_done;

  assign stretch_done = tick & at_limit(32'(cnt), 32'(STRETCH_US));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SEQ_HOLD;
      cnt   <= '0;
    end else if (fail) begin
      state <= SEQ_HOLD;
      cnt   <= '0;
    end else begin
      case (state)
        SEQ_HOLD: begin
          state <= SEQ_STRETCH;
          cnt   <= '0;
        end
        SEQ_STRETCH: begin
          if (stretch_done) begin
            state <= SEQ_RUN;
            cnt   <= '0;
          end else if (tick) begin
            cnt <= cnt + CW'(1);
          end
        end
        SEQ_RUN: begin
          if (pb_event) begin
            state <= SEQ_STRETCH;
            cnt   <= '0;
          end
        end
        default: begin
          state <= SEQ_HOLD;
          cnt   <= '0;
        end
      endcase
    end
  end

  assign hold_o = (state != SEQ_RUN);

  // R2: a failure forces the hold on the next edge
  p_fail_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fail |=> hold_o);

  // R4: release only ever happens on a tick
  p_release_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_o && $past(hold_o)) |-> $past(tick));

endmodule

// File: rtl/psv_ce_gate.sv
module psv_ce_gate #(
  parameter int GRACE_US = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic fail,
  input  logic ce_in_n,
  output logic ce_out_n
);
  import psv_pkg::*;

  localparam int CW = $clog2(GRACE_US + 1);

  logic          grace;
  logic [CW-1:0] gcnt;

  // While power is good, grace tracks whether an access is live.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grace <= 1'b0;
      gcnt  <= '0;
    end else if (!fail) begin
      grace <= ~ce_in_n;
      gcnt  <= '0;
    end else if (grace) begin
      if (ce_in_n) begin
        grace <= 1'b0;
      end else if (tick) begin
        if (at_limit(32'(gcnt), 32'(GRACE_US))) grace <= 1'b0;
        else                                    gcnt  <= gcnt + CW'(1);
      end
    end
  end

  assign ce_out_n = ce_in_n | (fail & ~grace);

  // R9: an enable that was idle during the failure stays blocked
  p_new_access_blocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && $past(fail) && $past(ce_in_n)) |-> ce_out_n);

  // R8: the grace window never runs past its tick limit
  p_grace_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !ce_out_n) |-> (32'(gcnt) < 32'(GRACE_US)));

endmodule

// File: rtl/pwr_supervisor.sv
module pwr_supervisor #(
  parameter int STRETCH_US = 200000,
  parameter int GRACE_US   = 100,
  parameter int PB_MIN_US  = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic us_tick,
  input  logic pwr_good,
  input  logic ce_in_n,
  input  logic rst_pin_in,
  input  logic per_req,
  input  logic alm_req,
  output logic rst_pull,
  output logic int_pull,
  output logic ce_out_n
);

  logic pf_flag;
  logic pb_event;

  // Power-fail flag; the block assumes a failure until power is seen good.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pf_flag <= 1'b1;
    else        pf_flag <= ~pwr_good;
  end

  psv_pin_qual #(.PB_MIN_US(PB_MIN_US)) u_pin_qual (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (us_tick),
    .pin_raw  (rst_pin_in),
    .pulling  (rst_pull),
    .pb_event (pb_event)
  );

  psv_rst_seq #(.STRETCH_US(STRETCH_US)) u_rst_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (us_tick),
    .fail     (pf_flag),
    .pb_event (pb_event),
    .hold_o   (rst_pull)
  );

  psv_ce_gate #(.GRACE_US(GRACE_US)) u_ce_gate (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (us_tick),
    .fail     (pf_flag),
    .ce_in_n  (ce_in_n),
    .ce_out_n (ce_out_n)
  );

  assign int_pull = pf_flag | per_req | alm_req;

  // R3: the warning interrupt is up one edge after the supply drops
  p_int_leads_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_good) |=> int_pull);

  // R2: a failure held for two samples keeps reset asserted
  p_reset_in_fail_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_good ##1 !pwr_good) |=> rst_pull);

  // R10: a pending request keeps the interrupt pulled
  p_int_pending_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (per_req || alm_req) |-> int_pull);

  // R7: no enable passes while power is sensed bad and no access was live
  p_ce_needs_power_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_out_n && !$past(!ce_in_n)) |-> $past(pwr_good));

endmodule

// File: tb/pwr_supervisor_tb.sv
module pwr_supervisor_tb;

  localparam int STRETCH = 12;
  localparam int GRACE   = 4;
  localparam int PBMIN   = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic us_tick = 1'b0;
  logic pwr_good = 1'b0;
  logic ce_in_n = 1'b1;
  logic per_req = 1'b0;
  logic alm_req = 1'b0;
  logic btn = 1'b0;
  logic rst_pin_in;
  logic rst_pull, int_pull, ce_out_n;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  assign rst_pin_in = ~(rst_pull | btn);

  pwr_supervisor #(.STRETCH_US(STRETCH), .GRACE_US(GRACE), .PB_MIN_US(PBMIN)) u_dut (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .pwr_good(pwr_good),
    .ce_in_n(ce_in_n), .rst_pin_in(rst_pin_in), .per_req(per_req),
    .alm_req(alm_req), .rst_pull(rst_pull), .int_pull(int_pull), .ce_out_n(ce_out_n)
  );

  // {pwr_good, ce_in_n, per_req, alm_req, exp_int_pull, exp_ce_out_n}
  localparam logic [5:0] VEC [9] = '{
    6'b1_1_0_0_0_1,
    6'b1_0_0_0_0_0,
    6'b1_0_1_0_1_0,
    6'b1_1_0_1_1_1,
    6'b1_0_1_1_1_0,
    6'b1_1_0_0_0_1,
    6'b0_1_0_0_1_1,
    6'b0_0_0_0_1_1,
    6'b0_0_1_0_1_1
  };

  task automatic step(input int n);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic ticks(input int n);
    repeat (n) begin
      us_tick = 1'b1;
      step(1);
      us_tick = 1'b0;
      step(1);
    end
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  initial begin
    #1_000_000;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    step(3);
    chk("R1 rst_pull", rst_pull, 1'b1);
    chk("R1 int_pull", int_pull, 1'b1);
    chk("R1 ce_out_n", ce_out_n, 1'b1);
    rst_n = 1'b1;
    step(3);
    chk("R1 power assumed bad", rst_pull, 1'b1);

    // Table: steady-state interrupt and enable behaviour (R7, R9, R10)
    pwr_good = 1'b1;
    step(3);
    for (int i = 0; i < 9; i++) begin
      pwr_good = VEC[i][5];
      ce_in_n  = VEC[i][4];
      per_req  = VEC[i][3];
      alm_req  = VEC[i][2];
      step(3);
      chk($sformatf("R10 int vec%0d", i), int_pull, VEC[i][1]);
      chk($sformatf("R7/R9 ce vec%0d", i), ce_out_n, VEC[i][0]);
    end
    per_req = 1'b0;
    ce_in_n = 1'b1;

    // R4: stretch after power returns
    step(2);
    chk("R2 held in failure", rst_pull, 1'b1);
    pwr_good = 1'b1;
    step(4);
    ticks(STRETCH - 1);
    chk("R4 before limit", rst_pull, 1'b1);
    ticks(1);
    chk("R4 at limit", rst_pull, 1'b0);

    // R3: interrupt one edge before reset
    pwr_good = 1'b0;
    step(1);
    chk("R3 int first", int_pull, 1'b1);
    chk("R3 reset not yet", rst_pull, 1'b0);
    step(1);
    chk("R3 reset follows", rst_pull, 1'b1);

    // R4: restart on failure mid-stretch
    pwr_good = 1'b1;
    step(4);
    ticks(5);
    pwr_good = 1'b0;
    step(3);
    chk("R2 mid-stretch failure", rst_pull, 1'b1);
    pwr_good = 1'b1;
    step(4);
    ticks(STRETCH - 1);
    chk("R4 restarted count", rst_pull, 1'b1);
    ticks(1);
    chk("R4 restarted release", rst_pull, 1'b0);
    chk("R10 idle int", int_pull, 1'b0);

    // R6: short button low ignored
    step(4);
    btn = 1'b1;
    step(3);
    ticks(PBMIN);
    btn = 1'b0;
    step(6);
    chk("R6 short low ignored", rst_pull, 1'b0);

    // R5: long button low starts a reset cycle
    btn = 1'b1;
    step(3);
    ticks(PBMIN + 1);
    btn = 1'b0;
    step(6);
    chk("R5 button reset", rst_pull, 1'b1);
    ticks(STRETCH - 1);
    chk("R5 stretch before limit", rst_pull, 1'b1);
    ticks(1);
    chk("R5 stretch release", rst_pull, 1'b0);

    // R8: grace ended by timeout, then R9
    step(4);
    ce_in_n = 1'b0;
    step(2);
    chk("R7 pass", ce_out_n, 1'b0);
    pwr_good = 1'b0;
    step(3);
    chk("R8 grace active", ce_out_n, 1'b0);
    ticks(GRACE - 1);
    chk("R8 before grace limit", ce_out_n, 1'b0);
    ticks(1);
    chk("R8 grace expired", ce_out_n, 1'b1);
    ce_in_n = 1'b1;
    step(2);
    ce_in_n = 1'b0;
    step(2);
    chk("R9 new access blocked", ce_out_n, 1'b1);

    // R8: grace ended by the enable going high
    ce_in_n = 1'b1;
    pwr_good = 1'b1;
    step(4);
    ce_in_n = 1'b0;
    step(2);
    pwr_good = 1'b0;
    step(3);
    ticks(1);
    chk("R8 grace held", ce_out_n, 1'b0);
    ce_in_n = 1'b1;
    #0.5;
    chk("R8 ends with enable", ce_out_n, 1'b1);
    step(2);
    ce_in_n = 1'b0;
    step(2);
    chk("R9 reentry blocked", ce_out_n, 1'b1);
    alm_req = 1'b1;
    step(1);
    chk("R10 alarm in failure", int_pull, 1'b1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule